// File: doc/BRIEF.md
# Multi-Line Transmit Scanner

This block arbitrates the transmit side of a serial multiplexer in which several lines share one host register window. The host sets one enable bit per line. A scanner polls the enabled lines one at a time and stops on the first line whose holding buffer has room. It then raises a ready flag and shows that line's number. The host answers with a single write to a shared transmit data register. That character is steered into the indicated line's holding buffer, and the scanner moves on.

The block holds no per-line data registers. One data port and one line-number field serve every line. The per-line serializers are outside the block. Each one appears as a `buf_free` input, which is high while its two-entry holding buffer can take a character. A load appears as a one-cycle, one-hot strobe on `ld_valid`, with the character on `ld_data`. An interrupt output follows the ready flag when the interrupt enable bit is set.

The scanner is a two-state machine:
- HUNT: it tests one line per clock, starting at a round-robin pointer. On a hit (HUNT to OFFER) it latches the line. On a miss (HUNT to HUNT) the pointer advances by one and wraps after the last line.
- OFFER: the ready flag is high. Two transitions return it to HUNT, and both set the pointer to the line after the one that was held. LOAD is a host data write. DROP is an enable write that clears the held line's bit. With neither present (OFFER to OFFER) it waits.

Top module: `txscan_top`

## Requirements
- R1: After reset, `tx_rdy`, `irq`, `line_en`, `ld_valid` and `tx_line` are all zero, and the scan pointer is at line 0.
- R2: A write on `en_we` replaces `line_en` with `en_wd` from the next cycle, where bit n enables line n. A line is offered only when it is enabled and its `buf_free` bit is high. An enabled line whose `buf_free` is low is never offered.
- R3: While `tx_rdy` is high, `tx_line` holds the offered line number and stays constant until LOAD or DROP. While `tx_rdy` is low, `tx_line` is 0.
- R4: A `tx_we` write while `tx_rdy` is high drives `ld_valid` in the same cycle, with only bit `tx_line` set, and drives `ld_data` equal to `tx_wd`. `tx_rdy` is low in the following cycle. If the same write also clears the line's enable bit, the character is still loaded.
- R5: A `tx_we` write while `tx_rdy` is low is ignored: `ld_valid` stays 0 and nothing is offered because of it.
- R6: Clearing the enable bit of the offered line while `tx_rdy` is high, without a data write, loads nothing and drops `tx_rdy` in the next cycle. Scanning resumes at the next line.
- R7: `irq` is high exactly when `tx_rdy` is high and the interrupt enable bit is set. That bit is written through `ien_we`/`ien_wd` and is 0 after reset.
- R8: After LOAD or DROP on line k, the search starts at line (k+1) mod NLINES. The next line offered is the first enabled line with buffer room, in increasing order with wrap-around.
- R9: The scanner tests one line per clock. If d lines are passed over before the hit, `tx_rdy` is low for exactly d+1 cycles after LOAD or DROP.
- R10: A line that stays enabled with buffer room after a load is offered again. If it is the only such line, it is offered again after NLINES cycles with `tx_rdy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_we | input | 1 | Write strobe for the line enable register |
| en_wd | input | NLINES | New line enable value, bit n for line n |
| ien_we | input | 1 | Write strobe for the interrupt enable bit |
| ien_wd | input | 1 | New interrupt enable value |
| tx_we | input | 1 | Write strobe for the shared transmit data register |
| tx_wd | input | DW | Character to transmit |
| buf_free | input | NLINES | Per-line flag, high when the holding buffer has room |
| line_en | output | NLINES | Current line enable register |
| tx_rdy | output | 1 | A line is being offered to the host |
| tx_line | output | clog2(NLINES) | Offered line number, 0 when idle |
| irq | output | 1 | Transmit-ready interrupt |
| ld_valid | output | NLINES | One-hot load strobe into a line's holding buffer |
| ld_data | output | DW | Character accompanying the load strobe |

## Verification
- `ld_valid` and `ld_data` are combinational from the write strobe. The bench therefore samples them one time step after it drives the write, inside the same cycle.
- `tx_rdy`, `tx_line`, `irq` and `line_en` are registered. Their response to a write is due one clock later, and the bench reads them at the next falling edge.
- A new offer after LOAD or DROP is due d+1 cycles later, where the bench computes d from its own enable and room masks and the restart line. The bench counts the low cycles exactly and compares the count and the offered line with that expectation.
- Enables and room flags are changed only on the same edge as the LOAD or DROP. As a result, the search that follows sees fixed inputs, and the expected timing is exact.

// File: rtl/txscan_pkg.sv
package txscan_pkg;
    typedef enum logic [0:0] {
        ST_HUNT  = 1'b0,
        ST_OFFER = 1'b1
    } scan_state_t;
endpackage

// File: rtl/txscan_regs.sv
module txscan_regs #(
    parameter int NLINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic [NLINES-1:0] en_wd,
    input  logic              ien_we,
    input  logic              ien_wd,
    output logic [NLINES-1:0] line_en,
    output logic              ien
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_en <= '0;
            ien     <= 1'b0;
        end else begin
            if (en_we)  line_en <= en_wd;
            if (ien_we) ien     <= ien_wd;
        end
    end
endmodule

// File: rtl/txscan_fsm.sv
module txscan_fsm
    import txscan_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int LW     = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] line_en,
    input  logic [NLINES-1:0] buf_free,
    input  logic              tx_we,
    input  logic              en_we,
    input  logic [NLINES-1:0] en_wd,
    output logic              offer,
    output logic [LW-1:0]     cur_line
);
    localparam logic [LW-1:0] LAST = LW'(NLINES - 1);

    scan_state_t   state, state_n;
    logic [LW-1:0] ptr, ptr_n;
    logic [LW-1:0] cur, cur_n;
    logic          hit;
    logic          drop;

    function automatic logic [LW-1:0] step(input logic [LW-1:0] v);
        if (v == LAST) return '0;
        return v + 1'b1;
    endfunction

    assign hit  = line_en[ptr] & buf_free[ptr];
    assign drop = en_we & ~en_wd[cur];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            ptr   <= '0;
            cur   <= '0;
        end else begin
            state <= state_n;
            ptr   <= ptr_n;
            cur   <= cur_n;
        end
    end

    // transitions: HUNT->OFFER on hit, HUNT->HUNT advances,
    // OFFER->HUNT on LOAD or DROP, OFFER->OFFER waits
    always_comb begin
        state_n = state;
        ptr_n   = ptr;
        cur_n   = cur;
        unique case (state)
            ST_HUNT: begin
                if (hit) begin
                    state_n = ST_OFFER;
                    cur_n   = ptr;
                end else begin
                    ptr_n = step(ptr);
                end
            end
            ST_OFFER: begin
                if (tx_we || drop) begin
                    state_n = ST_HUNT;
                    ptr_n   = step(cur);
                end
            end
            default: state_n = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        offer    = (state == ST_OFFER);
        cur_line = offer ? cur : '0;
    end
endmodule

// File: rtl/txscan_steer.sv
module txscan_steer #(
    parameter int NLINES = 8,
    parameter int DW     = 8,
    parameter int LW     = $clog2(NLINES)
) (
    input  logic              offer,
    input  logic [LW-1:0]     cur_line,
    input  logic              tx_we,
    input  logic [DW-1:0]     tx_wd,
    output logic [NLINES-1:0] ld_valid,
    output logic [DW-1:0]     ld_data
);
    logic go;
    assign go = offer & tx_we;

    for (genvar g = 0; g < NLINES; g++) begin : g_ld
        assign ld_valid[g] = go && (cur_line == LW'(g));
    end

    assign ld_data = go ? tx_wd : '0;
endmodule

// File: rtl/txscan_top.sv
module txscan_top #(
    parameter int NLINES = 8,
    parameter int DW     = 8,
    parameter int LW     = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic [NLINES-1:0] en_wd,
    input  logic              ien_we,
    input  logic              ien_wd,
    input  logic              tx_we,
    input  logic [DW-1:0]     tx_wd,
    input  logic [NLINES-1:0] buf_free,
    output logic [NLINES-1:0] line_en,
    output logic              tx_rdy,
    output logic [LW-1:0]     tx_line,
    output logic              irq,
    output logic [NLINES-1:0] ld_valid,
    output logic [DW-1:0]     ld_data
);
    logic ien_q;

    txscan_regs #(.NLINES(NLINES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (en_we),
        .en_wd   (en_wd),
        .ien_we  (ien_we),
        .ien_wd  (ien_wd),
        .line_en (line_en),
        .ien     (ien_q)
    );

    txscan_fsm #(.NLINES(NLINES), .LW(LW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_en  (line_en),
        .buf_free (buf_free),
        .tx_we    (tx_we),
        .en_we    (en_we),
        .en_wd    (en_wd),
        .offer    (tx_rdy),
        .cur_line (tx_line)
    );

    txscan_steer #(.NLINES(NLINES), .DW(DW), .LW(LW)) u_steer (
        .offer    (tx_rdy),
        .cur_line (tx_line),
        .tx_we    (tx_we),
        .tx_wd    (tx_wd),
        .ld_valid (ld_valid),
        .ld_data  (ld_data)
    );

    assign irq = tx_rdy & ien_q;
endmodule

// File: rtl/txscan_chk.sv
module txscan_chk #(
    parameter int NLINES = 8,
    parameter int DW     = 8,
    parameter int LW     = $clog2(NLINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_we,
    input logic [NLINES-1:0] en_wd,
    input logic              ien,
    input logic              tx_we,
    input logic [DW-1:0]     tx_wd,
    input logic [NLINES-1:0] buf_free,
    input logic [NLINES-1:0] line_en,
    input logic              tx_rdy,
    input logic [LW-1:0]     tx_line,
    input logic              irq,
    input logic [NLINES-1:0] ld_valid,
    input logic [DW-1:0]     ld_data
);
    logic [NLINES-1:0] free_prev, en_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_prev <= '0;
            en_prev   <= '0;
        end else begin
            free_prev <= buf_free;
            en_prev   <= line_en;
        end
    end

    AST_OFFER_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_rdy) |-> (en_prev[tx_line] && free_prev[tx_line])); // R2
    AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_rdy |-> (tx_line == '0)); // R3
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rdy && !tx_we && !(en_we && !en_wd[tx_line])) |=> (tx_rdy && $stable(tx_line))); // R3
    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_valid)); // R4
    AST_LOAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid != '0) |-> (ld_valid[tx_line] && ld_data == tx_wd)); // R4
    AST_LOAD_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rdy && tx_we) |=> !tx_rdy); // R4
    AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_rdy |-> (ld_valid == '0)); // R5
    AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rdy && !tx_we && en_we && !en_wd[tx_line]) |=> !tx_rdy); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tx_rdy && ien)); // R7
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_rdy && ien) |-> irq); // R7
endmodule

bind txscan_top txscan_chk #(.NLINES(NLINES), .DW(DW), .LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (en_we),
    .en_wd    (en_wd),
    .ien      (ien_q),
    .tx_we    (tx_we),
    .tx_wd    (tx_wd),
    .buf_free (buf_free),
    .line_en  (line_en),
    .tx_rdy   (tx_rdy),
    .tx_line  (tx_line),
    .irq      (irq),
    .ld_valid (ld_valid),
    .ld_data  (ld_data)
);

// File: tb/sim_txscan_top.sv
`timescale 1ns/1ps
module sim_txscan_top;
    localparam int N  = 8;
    localparam int DW = 8;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_we = 1'b0;
    logic [N-1:0]  en_wd = '0;
    logic          ien_we = 1'b0;
    logic          ien_wd = 1'b0;
    logic          tx_we = 1'b0;
    logic [DW-1:0] tx_wd = '0;
    logic [N-1:0]  buf_free = '0;
    logic [N-1:0]  line_en;
    logic          tx_rdy;
    logic [LW-1:0] tx_line;
    logic          irq;
    logic [N-1:0]  ld_valid;
    logic [DW-1:0] ld_data;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    txscan_top #(.NLINES(N), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wd(en_wd),
        .ien_we(ien_we), .ien_wd(ien_wd), .tx_we(tx_we), .tx_wd(tx_wd),
        .buf_free(buf_free), .line_en(line_en), .tx_rdy(tx_rdy),
        .tx_line(tx_line), .irq(irq), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // lines passed over before the first enabled line with room, or -1
    function automatic int pick_dist(input int p, input logic [N-1:0] en,
                                     input logic [N-1:0] fr);
        for (int i = 0; i < N; i++) begin
            if (en[(p + i) % N] && fr[(p + i) % N]) return i;
        end
        return -1;
    endfunction

    // called in the first low cycle after LOAD or DROP
    task automatic wait_offer(input int p, input logic [N-1:0] en,
                              input logic [N-1:0] fr, input string tag);
        int d;
        int cnt;
        d = pick_dist(p, en, fr);
        cnt = 0;
        while (!tx_rdy && cnt < 3 * N) begin
            cnt++;
            tick();
        end
        chk({"R9 low cycles ", tag}, cnt, d + 1);
        chk({"R8 offered line ", tag}, int'(tx_line), (p + d) % N);
    endtask

    task automatic serve(input logic [N-1:0] en, input logic [N-1:0] fr,
                         input logic [DW-1:0] ch, input string tag);
        int l;
        l = int'(tx_line);
        tx_we = 1'b1; tx_wd = ch; en_we = 1'b1; en_wd = en; buf_free = fr;
        #1;
        chk({"R4 ld_valid ", tag}, int'(ld_valid), 1 << l);
        chk({"R4 ld_data ", tag}, int'(ld_data), int'(ch));
        tick();
        tx_we = 1'b0; en_we = 1'b0;
        chk({"R4 rdy cleared ", tag}, int'(tx_rdy), 0);
        wait_offer((l + 1) % N, en, fr, tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int wait_n;
        logic [N-1:0] en_r, fr_r;
        void'($urandom(32'd4242));
        repeat (3) tick();
        // R1 reset state
        chk("R1 tx_rdy", int'(tx_rdy), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 line_en", int'(line_en), 0);
        chk("R1 ld_valid", int'(ld_valid), 0);
        chk("R3 tx_line idle", int'(tx_line), 0);
        rst_n = 1'b1;
        tick();

        // R5 write with nothing offered
        buf_free = '1;
        tx_we = 1'b1; tx_wd = 8'h5A;
        #1;
        chk("R5 ld_valid idle write", int'(ld_valid), 0);
        tick();
        tx_we = 1'b0;
        chk("R5 no offer after idle write", int'(tx_rdy), 0);

        // R2 enabled but no room: never offered
        en_we = 1'b1; en_wd = 8'h20; buf_free = 8'hDF;
        tick();
        en_we = 1'b0;
        chk("R2 line_en readback", int'(line_en), 8'h20);
        repeat (2 * N) tick();
        chk("R2 no room no offer", int'(tx_rdy), 0);

        // R2 room appears
        buf_free = 8'hFF;
        wait_n = 0;
        while (!tx_rdy && wait_n < 3 * N) begin wait_n++; tick(); end
        chk("R2 offered", int'(tx_rdy), 1);
        chk("R3 tx_line", int'(tx_line), 5);
        chk("R7 irq masked", int'(irq), 0);

        // R7 enable interrupt
        ien_we = 1'b1; ien_wd = 1'b1;
        tick();
        ien_we = 1'b0;
        chk("R7 irq on", int'(irq), 1);

        // R10 only line re-offered after N low cycles
        serve(8'h20, 8'hFF, 8'hC3, "R10");
        chk("R10 same line", int'(tx_line), 5);

        // R6 drop current line
        en_we = 1'b1; en_wd = 8'h0C;
        #1;
        chk("R6 no load on drop", int'(ld_valid), 0);
        tick();
        en_we = 1'b0;
        chk("R6 rdy dropped", int'(tx_rdy), 0);
        wait_offer(6, 8'h0C, 8'hFF, "after drop");

        // R3 offer held while other lines become eligible
        en_we = 1'b1; en_wd = 8'hFF;
        tick();
        en_we = 1'b0;
        repeat (5) tick();
        chk("R3 held rdy", int'(tx_rdy), 1);
        chk("R3 held line", int'(tx_line), 2);

        // R7 mask interrupt while ready
        ien_we = 1'b1; ien_wd = 1'b0;
        tick();
        chk("R7 irq masked ready", int'(irq), 0);
        ien_wd = 1'b1;
        tick();
        ien_we = 1'b0;

        // random service mixed with enable/room changes
        for (int it = 0; it < 300; it++) begin
            en_r = N'($urandom);
            fr_r = N'($urandom);
            if ((en_r & fr_r) == '0) begin
                int b;
                b = int'($urandom % N);
                en_r[b] = 1'b1;
                fr_r[b] = 1'b1;
            end
            serve(en_r, fr_r, DW'($urandom), "random");
            chk("R7 irq random", int'(irq), int'(tx_rdy));
        end

        finish_run();
    end
endmodule